// File: doc/BRIEF.md
# Flash Self-Programming Command Controller

This block lets a processor rewrite its own page-organized program flash. The processor arms a command by writing a small control register. A store strobe then has to follow within a short window, or the command lapses. A 16-bit Z address goes with each strobe. Its bit 0 picks a byte for byte reads, a middle field picks a word inside a page, and the bits above that pick the page.

Word loads fill a temporary page buffer one word at a time. A page write then commits the buffer to the selected page, and a page erase sets the selected page to all ones. The array behaves like real flash: a write can only clear bits. Programming a page that was never erased therefore leaves the AND of the old content and the buffer. For this reason the erase and the write each take their page from their own strobe. While a page operation runs, a halt output stops the processor. An EEPROM write that happens while the buffer is being filled throws the buffer away. A separate byte-read port returns one byte of any flash word.

Top module: `spm_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, `halt_o` is low, and every flash word and every buffer word is 0xFFFF.
- R2: A control write keeps only bits 0 (enable), 1 (erase), 2 (write) and 4 (buffer clear); all other bits read 0. Control writes while `halt_o` is high are ignored.
- R3: A command is accepted only if `spm_i` is high on one of the four clock edges that follow the control write. If no strobe comes in that window, the command bits read 0 after the fourth edge and a later strobe has no effect.
- R4: Command 0x01 (load) stores `data_i` into buffer word Z[5:1]. Z bit 0 and the page bits are ignored, and the control register reads 0 after the accepting edge.
- R5: Command 0x03 (erase) sets every word of page Z[8:6] to 0xFFFF.
- R6: Command 0x05 (write) sets each word of page Z[8:6] to its old value AND the buffer word. `data_i` is ignored.
- R7: Erase or write with any Z bit set outside bits [8:6] is rejected: `halt_o` stays low and the command bits read 0 after the strobe.
- R8: An accepted erase or write drives `halt_o` high for exactly BUSY_CYCLES cycles, starting the cycle after the strobe edge. At the end the control register reads 0 and every buffer word is 0xFFFF.
- R9: A cycle with `eep_we_i` high resets every buffer word to 0xFFFF, discarding all loaded words.
- R10: Command 0x11 (buffer clear) resets every buffer word to 0xFFFF without touching the flash.
- R11: `rd_byte_o` returns the low byte of word `rd_z_i[5:1]` of page `rd_z_i[8:6]` when `rd_z_i[0]` is 0, and the high byte when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| csr_we_i | input | 1 | Control register write enable |
| csr_wdata_i | input | 8 | Control register write data |
| csr_rdata_o | output | 8 | Control register contents |
| spm_i | input | 1 | Store strobe |
| z_i | input | 16 | Z address for the strobe |
| data_i | input | 16 | Word data for buffer loads |
| eep_we_i | input | 1 | EEPROM write indication |
| rd_z_i | input | 16 | Byte-read address |
| rd_byte_o | output | 8 | Byte read from flash |
| halt_o | output | 1 | CPU halt while a page operation runs |

## Verification
The bench probes the window edge. A strobe on the fourth cycle must take effect and one on the fifth must not. An off-by-one counter would either drop legal commands or accept stale ones. It writes a page that was never erased, to show that programming only clears bits, and it writes a fresh page with no loads, to show the buffer was cleared after a commit. A design that forgot to clear it would copy old data into the new page. It also sends erase and write with stray word, byte or high Z bits set, which a sloppy address check would let through and act on. It sends an EEPROM write between loads and a control write during halt; a design that got these wrong would keep stale words or change the command mid-operation.

// File: rtl/spm_pkg.sv
package spm_pkg;
  localparam int CTL_W = 5;
  localparam logic [CTL_W-1:0] CTL_MASK = 5'b10111;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_LOAD,
    CMD_ERASE,
    CMD_WRITE,
    CMD_CLRBUF
  } cmd_e;

  function automatic cmd_e decode_cmd(logic [CTL_W-1:0] bits);
    unique case (bits)
      5'h01:   return CMD_LOAD;
      5'h03:   return CMD_ERASE;
      5'h05:   return CMD_WRITE;
      5'h11:   return CMD_CLRBUF;
      default: return CMD_NONE;
    endcase
  endfunction
endpackage

// File: rtl/spm_arm.sv
module spm_arm
  import spm_pkg::*;
#(
  parameter int ARM_WINDOW = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       csr_we_i,
  input  logic [7:0] csr_wdata_i,
  input  logic       spm_i,
  input  logic       busy_i,
  input  logic       done_i,
  input  logic       keep_i,
  output logic [7:0] csr_o,
  output cmd_e       cmd_o,
  output logic       accept_o
);
  localparam int CW = $clog2(ARM_WINDOW + 1);

  logic [CW-1:0]    win_q;
  logic [CTL_W-1:0] ctl_q;
  logic [2:0]       unused_wdata;

  assign unused_wdata = csr_wdata_i[7:5];
  assign accept_o     = spm_i && (win_q != '0) && !busy_i && !csr_we_i;
  assign cmd_o        = decode_cmd(ctl_q);
  assign csr_o        = {3'b000, ctl_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
      ctl_q <= '0;
    end else if (csr_we_i && !busy_i) begin
      ctl_q <= csr_wdata_i[CTL_W-1:0] & CTL_MASK;
      win_q <= CW'(ARM_WINDOW);
    end else if (done_i) begin
      ctl_q <= '0;
    end else if (accept_o) begin
      win_q <= '0;
      if (!keep_i) ctl_q <= '0;
    end else if (win_q == CW'(1)) begin
      win_q <= '0;
      ctl_q <= '0;
    end else if (win_q != '0) begin
      win_q <= win_q - 1'b1;
    end
  end
endmodule

// File: rtl/spm_seq.sv
module spm_seq #(
  parameter int BUSY_CYCLES = 16,
  parameter int PAGE_AW     = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               erase_i,
  input  logic [PAGE_AW-1:0] page_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               erase_o,
  output logic [PAGE_AW-1:0] page_o
);
  localparam int TW = $clog2(BUSY_CYCLES + 1);

  logic [TW-1:0] tmr_q;

  assign busy_o = (tmr_q != '0);
  assign done_o = (tmr_q == TW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q   <= '0;
      erase_o <= 1'b0;
      page_o  <= '0;
    end else if (start_i) begin
      tmr_q   <= TW'(BUSY_CYCLES);
      erase_o <= erase_i;
      page_o  <= page_i;
    end else if (tmr_q != '0) begin
      tmr_q <= tmr_q - 1'b1;
    end
  end
endmodule

// File: rtl/spm_page_buf.sv
module spm_page_buf #(
  parameter int PAGE_WORDS = 32,
  parameter int DW         = 16,
  localparam int WORD_AW   = $clog2(PAGE_WORDS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         clear_i,
  input  logic                         load_i,
  input  logic [WORD_AW-1:0]           load_idx_i,
  input  logic [DW-1:0]                load_data_i,
  output logic [PAGE_WORDS-1:0][DW-1:0] buf_o
);
  for (genvar w = 0; w < PAGE_WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    buf_o[w] <= '1;
      else if (clear_i)                               buf_o[w] <= '1;
      else if (load_i && load_idx_i == WORD_AW'(w))   buf_o[w] <= load_data_i;
    end
  end
endmodule

// File: rtl/spm_flash_array.sv
module spm_flash_array #(
  parameter int NUM_PAGES  = 8,
  parameter int PAGE_WORDS = 32,
  parameter int DW         = 16,
  localparam int PAGE_AW   = $clog2(NUM_PAGES),
  localparam int WORD_AW   = $clog2(PAGE_WORDS)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          commit_i,
  input  logic                          erase_i,
  input  logic [PAGE_AW-1:0]            page_i,
  input  logic [PAGE_WORDS-1:0][DW-1:0] buf_i,
  input  logic [PAGE_AW-1:0]            rd_page_i,
  input  logic [WORD_AW-1:0]            rd_word_i,
  output logic [DW-1:0]                 rd_data_o
);
  logic [NUM_PAGES-1:0][PAGE_WORDS-1:0][DW-1:0] mem_q;

  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[p] <= '1;
      end else if (commit_i && page_i == PAGE_AW'(p)) begin
        // program can only clear bits
        if (erase_i) mem_q[p] <= '1;
        else         mem_q[p] <= mem_q[p] & buf_i;
      end
    end
  end

  assign rd_data_o = mem_q[rd_page_i][rd_word_i];
endmodule

// File: rtl/spm_ctrl.sv
module spm_ctrl
  import spm_pkg::*;
#(
  parameter int NUM_PAGES   = 8,
  parameter int PAGE_WORDS  = 32,
  parameter int BUSY_CYCLES = 16,
  parameter int ARM_WINDOW  = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        csr_we_i,
  input  logic [7:0]  csr_wdata_i,
  output logic [7:0]  csr_rdata_o,
  input  logic        spm_i,
  input  logic [15:0] z_i,
  input  logic [15:0] data_i,
  input  logic        eep_we_i,
  input  logic [15:0] rd_z_i,
  output logic [7:0]  rd_byte_o,
  output logic        halt_o
);
  localparam int DW      = 16;
  localparam int WORD_AW = $clog2(PAGE_WORDS);
  localparam int PAGE_AW = $clog2(NUM_PAGES);
  localparam int PG_LO   = WORD_AW + 1;
  localparam int PG_HI   = WORD_AW + PAGE_AW;
  localparam logic [15:0] PAGE_MASK = 16'(((1 << PAGE_AW) - 1) << PG_LO);

  cmd_e                          cmd;
  logic                          accept, busy, done, z_ok, start, is_page_op;
  logic                          load, clear, op_erase;
  logic [PAGE_AW-1:0]            op_page;
  logic [PAGE_WORDS-1:0][DW-1:0] buf_words;
  logic [DW-1:0]                 rd_word;
  logic                          unused_rd;

  assign z_ok       = (z_i & ~PAGE_MASK) == 16'h0000;
  assign is_page_op = (cmd == CMD_ERASE) || (cmd == CMD_WRITE);
  assign start      = accept && is_page_op && z_ok;
  assign load       = accept && (cmd == CMD_LOAD);
  assign clear      = done || eep_we_i || (accept && cmd == CMD_CLRBUF);
  assign halt_o     = busy;
  assign unused_rd  = ^{rd_z_i[15:PG_HI+1], z_i[0]};

  spm_arm #(.ARM_WINDOW(ARM_WINDOW)) u_arm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .csr_we_i    (csr_we_i),
    .csr_wdata_i (csr_wdata_i),
    .spm_i       (spm_i),
    .busy_i      (busy),
    .done_i      (done),
    .keep_i      (start),
    .csr_o       (csr_rdata_o),
    .cmd_o       (cmd),
    .accept_o    (accept)
  );

  spm_seq #(.BUSY_CYCLES(BUSY_CYCLES), .PAGE_AW(PAGE_AW)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .erase_i (cmd == CMD_ERASE),
    .page_i  (z_i[PG_HI:PG_LO]),
    .busy_o  (busy),
    .done_o  (done),
    .erase_o (op_erase),
    .page_o  (op_page)
  );

  spm_page_buf #(.PAGE_WORDS(PAGE_WORDS), .DW(DW)) u_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clear),
    .load_i      (load),
    .load_idx_i  (z_i[WORD_AW:1]),
    .load_data_i (data_i),
    .buf_o       (buf_words)
  );

  spm_flash_array #(.NUM_PAGES(NUM_PAGES), .PAGE_WORDS(PAGE_WORDS), .DW(DW)) u_flash (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .commit_i  (done),
    .erase_i   (op_erase),
    .page_i    (op_page),
    .buf_i     (buf_words),
    .rd_page_i (rd_z_i[PG_HI:PG_LO]),
    .rd_word_i (rd_z_i[WORD_AW:1]),
    .rd_data_o (rd_word)
  );

  assign rd_byte_o = rd_z_i[0] ? rd_word[15:8] : rd_word[7:0];
endmodule

// File: rtl/spm_ctrl_chk.sv
module spm_ctrl_chk #(
  parameter int BUSY_CYCLES = 16,
  parameter int ARM_WINDOW  = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       csr_we_i,
  input logic       spm_i,
  input logic [7:0] csr_rdata_o,
  input logic       halt_o
);
  localparam int SW = $clog2(ARM_WINDOW + 2);
  localparam int HW = $clog2(BUSY_CYCLES + 2);

  logic [SW-1:0] since_we_q;
  logic [HW-1:0] halt_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_we_q <= SW'(ARM_WINDOW + 1);
      halt_len_q <= '0;
    end else begin
      if (csr_we_i && !halt_o)                   since_we_q <= '0;
      else if (since_we_q != SW'(ARM_WINDOW + 1)) since_we_q <= since_we_q + 1'b1;
      halt_len_q <= halt_o ? halt_len_q + 1'b1 : '0;
    end
  end

  p_window_lapse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halt_o && since_we_q > SW'(ARM_WINDOW)) |-> (csr_rdata_o == 8'h00));

  p_halt_needs_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halt_o) |-> $past(spm_i));

  p_halt_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> (halt_len_q < HW'(BUSY_CYCLES)));

  p_halt_exact_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(halt_o) |-> (halt_len_q == HW'(BUSY_CYCLES) && csr_rdata_o == 8'h00));

  p_csr_frozen_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_o && $past(halt_o)) |-> $stable(csr_rdata_o));
endmodule

bind spm_ctrl spm_ctrl_chk #(.BUSY_CYCLES(BUSY_CYCLES), .ARM_WINDOW(ARM_WINDOW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .csr_we_i    (csr_we_i),
  .spm_i       (spm_i),
  .csr_rdata_o (csr_rdata_o),
  .halt_o      (halt_o)
);

// File: tb/spm_ctrl_tb.sv
module spm_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY       = 16;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [7:0]  csr_wdata = '0;
  logic [7:0]  csr_rdata;
  logic        spm = 1'b0;
  logic [15:0] z = '0;
  logic [15:0] data = '0;
  logic        eep_we = 1'b0;
  logic [15:0] rd_z = '0;
  logic [7:0]  rd_byte;
  logic        halt;

  int n_run = 0;
  int n_fail = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spm_ctrl #(.NUM_PAGES(8), .PAGE_WORDS(32), .BUSY_CYCLES(BUSY), .ARM_WINDOW(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .csr_we_i(csr_we), .csr_wdata_i(csr_wdata),
    .csr_rdata_o(csr_rdata), .spm_i(spm), .z_i(z), .data_i(data),
    .eep_we_i(eep_we), .rd_z_i(rd_z), .rd_byte_o(rd_byte), .halt_o(halt)
  );

  function automatic logic [15:0] z_of(int page, int word, int b);
    return 16'((page << 6) | (word << 1) | b);
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_csr(logic [7:0] v);
    csr_we = 1'b1; csr_wdata = v;
    tick(1);
    csr_we = 1'b0;
  endtask

  task automatic strobe(logic [15:0] zz, logic [15:0] d);
    spm = 1'b1; z = zz; data = d;
    tick(1);
    spm = 1'b0; z = '0; data = '0;
  endtask

  task automatic spm_cmd(logic [7:0] c, logic [15:0] zz, logic [15:0] d, int gap);
    wr_csr(c);
    tick(gap);
    strobe(zz, d);
  endtask

  task automatic wait_busy(output int n);
    n = 0;
    while (halt && n < 100) begin n++; tick(1); end
  endtask

  task automatic read_word(int page, int word, output logic [15:0] w);
    rd_z = z_of(page, word, 0); #1 w[7:0] = rd_byte;
    rd_z = z_of(page, word, 1); #1 w[15:8] = rd_byte;
  endtask

  task automatic check_word(string req, int page, int word, logic [15:0] exp);
    logic [15:0] w;
    read_word(page, word, w);
    check(req, w, exp);
  endtask

  task automatic page_op(logic [7:0] c, int page, string req);
    int n;
    spm_cmd(c, z_of(page, 0, 0), 16'h0000, 0);
    wait_busy(n);
    check(req, n, BUSY);
    check(req, csr_rdata, 0);
  endtask

  task automatic t_reset;
    check("R1 csr", csr_rdata, 0);
    check("R1 halt", halt, 0);
    check_word("R1 flash", 0, 0, 16'hFFFF);
    check_word("R1 flash", 7, 31, 16'hFFFF);
    page_op(8'h05, 1, "R1 buffer");
    check_word("R1 buffer", 1, 9, 16'hFFFF);
  endtask

  task automatic t_csr_mask;
    wr_csr(8'hFF);
    check("R2 mask", csr_rdata, 8'h17);
    tick(3);
    check("R3 still armed", csr_rdata, 8'h17);
    tick(1);
    check("R3 lapse", csr_rdata, 0);
  endtask

  task automatic t_load_write;
    spm_cmd(8'h01, z_of(7, 3, 1), 16'h1234, 0);
    check("R4 cmd cleared", csr_rdata, 0);
    page_op(8'h05, 2, "R8 write halt");
    check_word("R4 load", 2, 3, 16'h1234);
    check_word("R6 data ignored", 2, 0, 16'hFFFF);
    page_op(8'h05, 4, "R8 halt");
    check_word("R8 buffer cleared", 4, 3, 16'hFFFF);
  endtask

  task automatic t_and_erase;
    spm_cmd(8'h01, z_of(2, 3, 0), 16'hFF00, 0);
    page_op(8'h05, 2, "R6 halt");
    check_word("R6 and", 2, 3, 16'h1200);
    page_op(8'h03, 2, "R5 erase halt");
    check_word("R5 erase", 2, 3, 16'hFFFF);
    spm_cmd(8'h01, z_of(2, 3, 0), 16'hFF00, 0);
    page_op(8'h05, 2, "R6 halt");
    check_word("R6 after erase", 2, 3, 16'hFF00);
  endtask

  task automatic t_window;
    int n;
    spm_cmd(8'h01, z_of(0, 7, 0), 16'h0000, 4);
    check("R3 late load csr", csr_rdata, 0);
    page_op(8'h05, 5, "R3 halt");
    check_word("R3 late load ignored", 5, 7, 16'hFFFF);
    spm_cmd(8'h05, z_of(5, 0, 0), 16'h0000, 3);
    check("R3 last slot", halt, 1);
    wait_busy(n);
    check("R3 last slot len", n, BUSY);
    spm_cmd(8'h05, z_of(5, 0, 0), 16'h0000, 4);
    check("R3 expired", halt, 0);
    tick(2);
    check("R3 expired", halt, 0);
  endtask

  task automatic t_bad_z;
    spm_cmd(8'h05, z_of(1, 1, 0), 16'h0000, 0);
    check("R7 word bits", halt, 0);
    check("R7 csr", csr_rdata, 0);
    spm_cmd(8'h03, z_of(1, 0, 1), 16'h0000, 0);
    check("R7 byte bit", halt, 0);
    spm_cmd(8'h03, 16'h8000 | z_of(1, 0, 0), 16'h0000, 1);
    check("R7 high bit", halt, 0);
    check("R7 csr", csr_rdata, 0);
  endtask

  task automatic t_eep;
    spm_cmd(8'h01, z_of(6, 0, 0), 16'h0000, 0);
    eep_we = 1'b1; tick(1); eep_we = 1'b0;
    spm_cmd(8'h01, z_of(6, 1, 0), 16'h0000, 0);
    page_op(8'h05, 6, "R9 halt");
    check_word("R9 discarded", 6, 0, 16'hFFFF);
    check_word("R9 later load", 6, 1, 16'h0000);
  endtask

  task automatic t_clrbuf;
    spm_cmd(8'h01, z_of(7, 2, 0), 16'h0000, 0);
    spm_cmd(8'h11, z_of(7, 0, 0), 16'h0000, 1);
    check("R10 no halt", halt, 0);
    check("R10 csr", csr_rdata, 0);
    check_word("R10 flash untouched", 7, 2, 16'hFFFF);
    page_op(8'h05, 7, "R10 halt");
    check_word("R10 cleared", 7, 2, 16'hFFFF);
  endtask

  task automatic t_byte_read;
    rd_z = z_of(2, 3, 0); #1 check("R11 low byte", rd_byte, 8'h00);
    rd_z = z_of(2, 3, 1); #1 check("R11 high byte", rd_byte, 8'hFF);
    rd_z = z_of(6, 1, 1); #1 check("R11 high byte", rd_byte, 8'h00);
  endtask

  task automatic t_busy_csr;
    int n;
    spm_cmd(8'h05, z_of(3, 0, 0), 16'h0000, 0);
    tick(2);
    wr_csr(8'h01);
    check("R2 busy write ignored", csr_rdata, 8'h05);
    wait_busy(n);
    check("R2 halt released", halt, 0);
    check("R2 csr after", csr_rdata, 0);
  endtask

  task automatic finish_run;
    if (!done_flag) begin
      done_flag = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_csr_mask();
    t_load_write();
    t_and_erase();
    t_window();
    t_bad_z();
    t_eep();
    t_clrbuf();
    t_byte_read();
    t_busy_csr();
    finish_run();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule